// File: doc/BRIEF.md
# Fractional-Ratio Maintenance Clock Generator

This block turns a fast system clock into a nominal 256 kHz maintenance clock enable. It divides by a non-integer ratio chosen by the line-rate mode, and can then slow the result further by a power of two. The fractional ratio is held as a fixed-point number with 9 integer bits and 5 fractional bits. A phase accumulator picks each period as either the floor or the ceiling of that ratio, so that the long-term average rate is exact. The output is a single-cycle enable pulse. It serves as the reference for a downstream receive-clock recovery DPLL and also as a low-rate tick for maintenance logic.

The block has no streaming interface and therefore no valid/ready handshake. The mode and rate selects are plain quasi-static control inputs. The output pulse cannot be back-pressured: a consumer that misses a pulse loses it. Changes to either select are picked up only at period boundaries. A change therefore never produces a shortened or stretched period.

Top module: `mcg_maint_clk_gen`

## Requirements
- R1: The base divide ratio, counted in 1/32 system cycles, depends on `line_mode` as follows: code 0 uses 8685 (271.40625), code 1 uses 8448 (264), code 2 uses 8679 (271.21875), code 3 uses 8448 (264), code 4 uses 8592 (268.5), code 5 uses 8388 (262.125) and code 6 uses 9720 (303.75). Code 7 uses the same ratio as code 0.
- R2: Let R be the ratio from R1. Counting rising edges from the first edge with `rst` low as edge 1, the n-th base period ends at edge ceil(n·R/32). With `rate_sel` = 0, `tick_out` is high exactly in the cycle after each of those edges.
- R3: For `rate_sel` codes 1 to 5 the divisor is D = 2^code. The m-th pulse of `tick_out` follows edge ceil(m·D·R/32).
- R4: `rate_sel` code 0 applies no post-division, and codes 6 and 7 divide by 32.
- R5: Each pulse of `tick_out` lasts exactly one system-clock cycle.
- R6: A change of `line_mode` does not alter the period in progress. The new ratio applies from the next base period onward, and the fractional residue carries over.
- R7: A change of `rate_sel` does not alter the output period in progress. The new divisor applies after the next `tick_out` pulse.
- R8: A synchronous `rst` clears the phase accumulator and the post-divider count and holds `tick_out` low. The `line_mode` and `rate_sel` values present during reset are the ones in force for the first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_mode | input | 3 | Line-rate mode, selects the fractional ratio |
| rate_sel | input | 3 | Post-divider select |
| tick_out | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
If the accumulator holds a wrong residue or is loaded with a wrong ratio, the error shows as a pulse that is early or late by one cycle. It appears at the first period in which the floor/ceiling choice goes the other way, at most a few base periods into a fractional mode. A wrong post-divider count or a divisor latched at the wrong moment moves the very next output pulse by a whole base period. A select latched at the wrong time shows up in the first period after the change. Comparing every pulse against its exact expected cycle number therefore catches both kinds of fault within one or two output periods.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  localparam int MODE_W    = 3;
  localparam int RATE_W    = 3;
  localparam int FRAC_W    = 5;
  localparam int INT_W     = 9;
  localparam int RATIO_W   = INT_W + FRAC_W;
  localparam int ACC_W     = RATIO_W + 1;
  localparam int SHIFT_MAX = 5;
  localparam int CNT_W     = SHIFT_MAX;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [ACC_W-1:0]   acc_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // fixed-point constant: integer part plus numerator over 2^FRAC_W
  function automatic ratio_t fx(input int ip, input int fp);
    return ratio_t'((ip << FRAC_W) + fp);
  endfunction

  function automatic ratio_t mode_ratio(input logic [MODE_W-1:0] m);
    ratio_t r;
    case (m)
      3'd1, 3'd3: r = fx(264, 0);
      3'd2:       r = fx(271, 7);
      3'd4:       r = fx(268, 16);
      3'd5:       r = fx(262, 4);
      3'd6:       r = fx(303, 24);
      default:    r = fx(271, 13);
    endcase
    return r;
  endfunction

  // terminal count of the post divider (divisor minus one)
  function automatic cnt_t rate_last(input logic [RATE_W-1:0] code);
    int sh;
    sh = (int'(code) > SHIFT_MAX) ? SHIFT_MAX : int'(code);
    return cnt_t'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/mcg_phase_acc.sv
module mcg_phase_acc
  import mcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] line_mode,
  output logic              base_tick
);
  localparam acc_t STEP = acc_t'(1 << FRAC_W);

  acc_t   acc_q;
  ratio_t ratio_q;
  acc_t   acc_next;
  logic   wrap_hit;

  always_comb begin
    acc_next = acc_q + STEP;
    wrap_hit = (acc_next >= {1'b0, ratio_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      ratio_q   <= mode_ratio(line_mode);
      base_tick <= 1'b0;
    end else if (wrap_hit) begin
      acc_q     <= acc_next - {1'b0, ratio_q};
      ratio_q   <= mode_ratio(line_mode);
      base_tick <= 1'b1;
    end else begin
      acc_q     <= acc_next;
      base_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/mcg_post_div.sv
module mcg_post_div
  import mcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              base_tick,
  output logic              tick_out
);
  cnt_t cnt_q;
  cnt_t last_q;
  logic at_last;

  always_comb begin
    at_last  = (cnt_q == last_q);
    tick_out = base_tick & at_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= rate_last(rate_sel);
    end else if (base_tick) begin
      if (at_last) begin
        cnt_q  <= '0;
        last_q <= rate_last(rate_sel);
      end else begin
        cnt_q  <= cnt_q + cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/mcg_maint_clk_gen.sv
module mcg_maint_clk_gen
  import mcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] line_mode,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              tick_out
);
  logic base_tick;

  mcg_phase_acc i_phase (
    .clk       (clk),
    .rst       (rst),
    .line_mode (line_mode),
    .base_tick (base_tick)
  );

  mcg_post_div i_post (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .base_tick (base_tick),
    .tick_out  (tick_out)
  );
endmodule

// File: rtl/mcg_check.sv
module mcg_check (
  input logic clk,
  input logic rst,
  input logic base_tick,
  input logic tick_out
);
  localparam int GAP_W  = 10;
  localparam int GAP_LO = 256;
  localparam int GAP_HI = 310;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || base_tick) gap_q <= '0;
    else if (gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  AST_BASE_SPACING: assert property (@(posedge clk) disable iff (rst)
    base_tick |-> (int'(gap_q) >= GAP_LO && int'(gap_q) <= GAP_HI)); // R2
  AST_BASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> !base_tick); // R5
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_out |=> !tick_out); // R5
  AST_OUT_ON_BASE: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> base_tick); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!base_tick && !tick_out)); // R8
endmodule

bind mcg_maint_clk_gen mcg_check i_chk (
  .clk       (clk),
  .rst       (rst),
  .base_tick (base_tick),
  .tick_out  (tick_out)
);

// File: tb/test_mcg_maint_clk_gen.sv
module test_mcg_maint_clk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] line_mode = 3'd0;
  logic [2:0] rate_sel = 3'd0;
  logic       tick_out;

  int    cyc = 0;
  int    errors = 0;
  int    checks = 0;
  int    total = 0;
  string cur_req = "R8";
  int    exp_q[$];
  logic  prev_tick = 1'b0;

  always #5 clk = ~clk;

  mcg_maint_clk_gen i_mcg_maint_clk_gen (
    .clk(clk), .rst(rst), .line_mode(line_mode),
    .rate_sel(rate_sel), .tick_out(tick_out)
  );

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // ratio in 32nds of a cycle, per R1
  function automatic longint ref_r32(input int m);
    case (m)
      1, 3: return 8448;
      2:    return 8679;
      4:    return 8592;
      5:    return 8388;
      6:    return 9720;
      default: return 8685;
    endcase
  endfunction

  function automatic longint ref_div(input int code);
    if (code == 0) return 1;
    if (code > 5) return 32;
    return longint'(1) << code;
  endfunction

  function automatic int ceil32(input longint v);
    return int'((v + 31) / 32);
  endfunction

  // monitor
  always @(negedge clk) begin
    total <= total + 1;
    if (!rst) begin
      if (prev_tick) begin
        checks++;
        if (tick_out) begin
          errors++;
          $display("FAIL R5 pulse wider than one cycle at %0d: got 1 expected 0", cyc);
        end
      end
      if (tick_out) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected pulse at cycle %0d, expected none", cur_req, cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            errors++;
            $display("FAIL %s pulse at cycle %0d, expected %0d", cur_req, cyc, e);
          end
        end
      end
    end
    prev_tick <= tick_out;
  end

  task automatic apply_reset(input int m, input int r);
    @(negedge clk);
    rst = 1'b1; line_mode = 3'(m); rate_sel = 3'(r);
    exp_q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (tick_out !== 1'b0) begin
      errors++;
      $display("FAIL R8 output during reset: got %b expected 0", tick_out);
    end
    rst = 1'b0;
  endtask

  task automatic drain(input int until_cyc);
    while (cyc < until_cyc) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing pulses: %0d left, expected 0", cur_req, exp_q.size());
    end
  endtask

  task automatic run_case(input int m, input int r, input int n, input string req);
    longint rr, dd;
    int last;
    cur_req = req;
    apply_reset(m, r);
    rr = ref_r32(m);
    dd = ref_div(r);
    last = 0;
    for (int k = 1; k <= n; k++) begin
      last = ceil32(longint'(k) * dd * rr);
      exp_q.push_back(last);
    end
    drain(last + 20);
  endtask

  initial begin
    run_case(0, 0, 10, "R2");   // fractional 271.40625, rate code 0
    run_case(1, 0, 5,  "R1");   // integer 264
    run_case(2, 1, 5,  "R3");   // divide by 2
    run_case(4, 0, 8,  "R2");   // half-cycle fraction alternates
    run_case(5, 2, 4,  "R3");   // divide by 4
    run_case(6, 5, 2,  "R4");   // divide by 32, slowest ratio
    run_case(3, 7, 2,  "R4");   // code 7 treated as 32
    run_case(7, 0, 4,  "R1");   // mode 7 same as mode 0

    // R6: mode change mid-period takes effect after the current period
    cur_req = "R6";
    apply_reset(1, 0);
    exp_q.push_back(264);
    for (int k = 1; k <= 4; k++) exp_q.push_back(264 + ceil32(longint'(k) * 8388));
    while (cyc < 100) @(negedge clk);
    line_mode = 3'd5;
    drain(264 + ceil32(4 * 8388) + 20);

    // R7: rate change mid output period waits for next output pulse
    cur_req = "R7";
    apply_reset(1, 1);
    exp_q.push_back(528);
    exp_q.push_back(1056);
    exp_q.push_back(1320);
    exp_q.push_back(1584);
    exp_q.push_back(1848);
    while (cyc < 600) @(negedge clk);
    rate_sel = 3'd0;
    drain(1870);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (total > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run exceeded limit, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule